// File: doc/BRIEF.md
# Word-Address Instruction Fetch Unit

This block keeps the program counter of a single-cycle processor as a 30-bit word index and derives the 32-bit byte fetch address from it by appending two zero bits. On every rising clock edge it loads a new counter value. That value is chosen from three candidates: the next sequential word, a relative branch destination, or an absolute jump destination. Branch, jump and the ALU zero flag come from the surrounding datapath. The 16-bit offset and the 26-bit jump field are supplied by the instruction currently being executed.

The instruction store sits inside the block and is read combinationally at the current counter value. A simple write port fills it. The port is intended for a testbench or for boot-time loading. Decoding, the ALU and any form of stall belong to other blocks.

Top module: `wfetch_unit`

## Requirements
- R1: When `rst` is high at a rising edge, `pc` is 0 after that edge. This has priority over branch and jump.
- R2: `fetch_addr` always equals `pc` shifted left by two, with bits [1:0] equal to 0.
- R3: When `jump` is low and `branch` and `zero` are not both high, the next `pc` is `pc + 1`.
- R4: When `branch` and `zero` are both high and `jump` is low, the next `pc` is `pc + 1` plus `imm16` sign-extended to 30 bits.
- R5: `branch` alone, or `zero` alone, does not redirect the counter. The next `pc` is `pc + 1`.
- R6: When `jump` is high, the next `pc` is {current `pc[29:26]`, `jtarget[25:0]`}. The upper four bits are kept from the current counter.
- R7: `jump` takes priority over a taken branch when both are requested in the same cycle.
- R8: All counter arithmetic wraps modulo 2^30. For example, `pc = 30'h3FFFFFFF` followed by a sequential step gives 0.
- R9: `instr` shows the stored word at index `pc[IMEM_AW-1:0]` combinationally. A write through `load_en`, `load_addr` and `load_data` takes effect at the rising edge, and reset does not clear it.
- R10: A negative offset (bit 15 of `imm16` set) moves the counter backward. For example, `pc = 10` with offset `16'hFFFD` gives 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the counter and store writes update on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| branch | input | 1 | Current instruction is a conditional branch |
| zero | input | 1 | ALU equality flag |
| jump | input | 1 | Current instruction is an absolute jump |
| imm16 | input | 16 | Signed word offset for branches |
| jtarget | input | 26 | Jump field of the current instruction |
| load_en | input | 1 | Write strobe for the instruction store |
| load_addr | input | IMEM_AW (6) | Word index written by the load port |
| load_data | input | 32 | Word written by the load port |
| fetch_addr | output | 32 | Byte address of the current instruction |
| pc | output | 30 | Current word-index program counter |
| instr | output | 32 | Instruction word at the current counter |

## Verification
The vector walk includes branch and zero each raised alone. A design that used OR instead of AND would jump by the offset there. It also includes a jump raised together with a taken branch, which a design with the wrong priority would turn into a relative move. A backward offset taken from address 0 must wrap to 30'h3FFFFFFF, and a following jump must keep the upper bits 4'hF. A design that zero-extended the offset, dropped the upper bits or carried into a 31st bit would land elsewhere. Further tests cover reset asserted alongside a jump, and a store write at the address currently being fetched, which must show on `instr` after the edge.

// File: rtl/wfetch_pkg.sv
package wfetch_pkg;

  typedef enum logic [1:0] {
    SEL_SEQ    = 2'd0,
    SEL_BRANCH = 2'd1,
    SEL_JUMP   = 2'd2
  } pc_sel_e;

  localparam int unsigned DEF_PC_W    = 30;
  localparam int unsigned DEF_IMM_W   = 16;
  localparam int unsigned DEF_TGT_W   = 26;
  localparam int unsigned DEF_INSTR_W = 32;
  localparam int unsigned DEF_IMEM_AW = 6;

endpackage

// File: rtl/wfetch_sel.sv
module wfetch_sel
  import wfetch_pkg::*;
(
  input  logic    branch,
  input  logic    zero,
  input  logic    jump,
  output pc_sel_e sel,
  output logic    take_branch,
  output logic    take_jump
);

  // jump outranks a taken branch
  always_comb begin
    take_jump   = jump;
    take_branch = branch & zero & ~jump;
    if (take_jump)
      sel = SEL_JUMP;
    else if (take_branch)
      sel = SEL_BRANCH;
    else
      sel = SEL_SEQ;
  end

endmodule

// File: rtl/wfetch_next_pc.sv
module wfetch_next_pc
  import wfetch_pkg::*;
#(
  parameter int unsigned PC_W  = DEF_PC_W,
  parameter int unsigned IMM_W = DEF_IMM_W,
  parameter int unsigned TGT_W = DEF_TGT_W
) (
  input  logic [PC_W-1:0]  pc_cur,
  input  pc_sel_e          sel,
  input  logic [IMM_W-1:0] imm,
  input  logic [TGT_W-1:0] tgt,
  output logic [PC_W-1:0]  seq_pc,
  output logic [PC_W-1:0]  pc_nxt
);

  localparam int unsigned UPPER_W = PC_W - TGT_W;

  function automatic logic [PC_W-1:0] step_one(input logic [PC_W-1:0] p);
    return p + PC_W'(1);
  endfunction

  function automatic logic [PC_W-1:0] sext_off(input logic [IMM_W-1:0] o);
    return PC_W'($signed(o));
  endfunction

  function automatic logic [PC_W-1:0] jump_dest(input logic [PC_W-1:0] p,
                                                input logic [TGT_W-1:0] t);
    return {p[PC_W-1 -: UPPER_W], t};
  endfunction

  logic [PC_W-1:0] br_pc;
  logic [PC_W-1:0] jmp_pc;

  always_comb begin
    seq_pc = step_one(pc_cur);
    br_pc  = seq_pc + sext_off(imm);
    jmp_pc = jump_dest(pc_cur, tgt);
    case (sel)
      SEL_BRANCH: pc_nxt = br_pc;
      SEL_JUMP:   pc_nxt = jmp_pc;
      default:    pc_nxt = seq_pc;
    endcase
  end

endmodule

// File: rtl/wfetch_pc_reg.sv
module wfetch_pc_reg #(
  parameter int unsigned PC_W = 30
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PC_W-1:0] d,
  output logic [PC_W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end

endmodule

// File: rtl/wfetch_imem.sv
module wfetch_imem #(
  parameter int unsigned AW = 6,
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/wfetch_unit.sv
module wfetch_unit
  import wfetch_pkg::*;
#(
  parameter int unsigned PC_W    = DEF_PC_W,
  parameter int unsigned IMM_W   = DEF_IMM_W,
  parameter int unsigned TGT_W   = DEF_TGT_W,
  parameter int unsigned INSTR_W = DEF_INSTR_W,
  parameter int unsigned IMEM_AW = DEF_IMEM_AW
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                branch,
  input  logic                zero,
  input  logic                jump,
  input  logic [IMM_W-1:0]    imm16,
  input  logic [TGT_W-1:0]    jtarget,
  input  logic                load_en,
  input  logic [IMEM_AW-1:0]  load_addr,
  input  logic [INSTR_W-1:0]  load_data,
  output logic [PC_W+1:0]     fetch_addr,
  output logic [PC_W-1:0]     pc,
  output logic [INSTR_W-1:0]  instr
);

  pc_sel_e         sel_w;
  logic            take_branch_w;
  logic            take_jump_w;
  logic [PC_W-1:0] seq_pc_w;
  logic [PC_W-1:0] pc_nxt_w;

  wfetch_sel u_sel (
    .branch      (branch),
    .zero        (zero),
    .jump        (jump),
    .sel         (sel_w),
    .take_branch (take_branch_w),
    .take_jump   (take_jump_w)
  );

  wfetch_next_pc #(
    .PC_W  (PC_W),
    .IMM_W (IMM_W),
    .TGT_W (TGT_W)
  ) u_npc (
    .pc_cur (pc),
    .sel    (sel_w),
    .imm    (imm16),
    .tgt    (jtarget),
    .seq_pc (seq_pc_w),
    .pc_nxt (pc_nxt_w)
  );

  wfetch_pc_reg #(.PC_W(PC_W)) u_pc (
    .clk (clk),
    .rst (rst),
    .d   (pc_nxt_w),
    .q   (pc)
  );

  wfetch_imem #(.AW(IMEM_AW), .DW(INSTR_W)) u_mem (
    .clk   (clk),
    .we    (load_en),
    .waddr (load_addr),
    .wdata (load_data),
    .raddr (pc[IMEM_AW-1:0]),
    .rdata (instr)
  );

  assign fetch_addr = {pc, 2'b00};

endmodule

// File: rtl/wfetch_unit_chk.sv
module wfetch_unit_chk #(
  parameter int unsigned PC_W  = 30,
  parameter int unsigned IMM_W = 16,
  parameter int unsigned TGT_W = 26
) (
  input logic             clk,
  input logic             rst,
  input logic             branch,
  input logic             zero,
  input logic             jump,
  input logic [IMM_W-1:0] imm16,
  input logic [TGT_W-1:0] jtarget,
  input logic [PC_W+1:0]  fetch_addr,
  input logic [PC_W-1:0]  pc,
  input logic [PC_W-1:0]  seq_pc,
  input logic             take_branch,
  input logic             take_jump
);

  localparam int unsigned UPPER_W = PC_W - TGT_W;

  logic [PC_W-1:0] off_ext;
  assign off_ext = {{(PC_W-IMM_W){imm16[IMM_W-1]}}, imm16};

  p_reset_r1: assert property (@(posedge clk) rst |=> pc == '0);

  p_align_r2: assert property (@(posedge clk) disable iff (rst)
    fetch_addr[1:0] == 2'b00);

  p_seq_r3: assert property (@(posedge clk) disable iff (rst)
    (!jump && !(branch && zero)) |=> pc == $past(pc) + PC_W'(1));

  p_branch_r4: assert property (@(posedge clk) disable iff (rst)
    (branch && zero && !jump) |=> (pc - $past(pc)) == $past(off_ext) + PC_W'(1));

  p_jump_r6: assert property (@(posedge clk) disable iff (rst)
    jump |=> (pc[TGT_W-1:0] == $past(jtarget)) &&
             (pc[PC_W-1 -: UPPER_W] == $past(pc[PC_W-1 -: UPPER_W])));

  p_one_redirect_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0({take_jump, take_branch}));

  p_seq_wrap_r8: assert property (@(posedge clk) disable iff (rst)
    (pc == '1) |-> seq_pc == '0);

endmodule

bind wfetch_unit wfetch_unit_chk #(
  .PC_W  (PC_W),
  .IMM_W (IMM_W),
  .TGT_W (TGT_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .branch      (branch),
  .zero        (zero),
  .jump        (jump),
  .imm16       (imm16),
  .jtarget     (jtarget),
  .fetch_addr  (fetch_addr),
  .pc          (pc),
  .seq_pc      (seq_pc_w),
  .take_branch (take_branch_w),
  .take_jump   (take_jump_w)
);

// File: tb/wfetch_unit_test.sv
module wfetch_unit_test;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 14;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        branch = 1'b0, zero = 1'b0, jump = 1'b0;
  logic [15:0] imm16 = '0;
  logic [25:0] jtarget = '0;
  logic        load_en = 1'b0;
  logic [5:0]  load_addr = '0;
  logic [31:0] load_data = '0;
  logic [31:0] fetch_addr;
  logic [29:0] pc;
  logic [31:0] instr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // {branch, zero, jump, imm16, jtarget, expected pc after the edge}
  localparam logic [74:0] VECS [NVEC] = '{
    {1'b0, 1'b0, 1'b0, 16'h0000, 26'h0000000, 30'h00000001}, // R3
    {1'b0, 1'b0, 1'b0, 16'h0000, 26'h0000000, 30'h00000002}, // R3
    {1'b1, 1'b0, 1'b0, 16'h0005, 26'h0000000, 30'h00000003}, // R5 branch alone
    {1'b0, 1'b1, 1'b0, 16'h0005, 26'h0000000, 30'h00000004}, // R5 zero alone
    {1'b1, 1'b1, 1'b0, 16'h0005, 26'h0000000, 30'h0000000A}, // R4
    {1'b1, 1'b1, 1'b0, 16'hFFFD, 26'h0000000, 30'h00000008}, // R10 backward
    {1'b0, 1'b0, 1'b1, 16'h0000, 26'h0000020, 30'h00000020}, // R6
    {1'b1, 1'b1, 1'b1, 16'h0004, 26'h0000011, 30'h00000011}, // R7 jump wins
    {1'b1, 1'b1, 1'b0, 16'hFFEE, 26'h0000000, 30'h00000000}, // R10 back to 0
    {1'b1, 1'b1, 1'b0, 16'hFFFE, 26'h0000000, 30'h3FFFFFFF}, // R8 wrap down
    {1'b0, 1'b0, 1'b1, 16'h0000, 26'h0000003, 30'h3C000003}, // R6 upper bits kept
    {1'b1, 1'b1, 1'b0, 16'h7FFF, 26'h0000000, 30'h3C008003}, // R4 max offset
    {1'b0, 1'b0, 1'b1, 16'h0000, 26'h3FFFFFF, 30'h3FFFFFFF}, // R6
    {1'b0, 1'b0, 1'b0, 16'h0000, 26'h0000000, 30'h00000000}  // R8 wrap up
  };

  wfetch_unit uut (
    .clk        (clk),
    .rst        (rst),
    .branch     (branch),
    .zero       (zero),
    .jump       (jump),
    .imm16      (imm16),
    .jtarget    (jtarget),
    .load_en    (load_en),
    .load_addr  (load_addr),
    .load_data  (load_data),
    .fetch_addr (fetch_addr),
    .pc         (pc),
    .instr      (instr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  function automatic logic [31:0] word_at(input int i);
    return 32'hC0DE_0000 + 32'(i * 17);
  endfunction

  initial begin
    #(CLK_PERIOD * 5000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // fill the store while reset is held (R9)
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      load_en = 1'b1; load_addr = 6'(i); load_data = word_at(i);
    end
    @(negedge clk);
    load_en = 1'b0;
    rst = 1'b0;
    #1;
    check("R1 reset pc", 32'(pc), 32'h0);
    check("R2 reset fetch_addr", fetch_addr, 32'h0);
    check("R9 instr at 0", instr, word_at(0));

    for (int v = 0; v < NVEC; v++) begin
      logic [29:0] exp_pc;
      string tag;
      branch  = VECS[v][74];
      zero    = VECS[v][73];
      jump    = VECS[v][72];
      imm16   = VECS[v][71:56];
      jtarget = VECS[v][55:30];
      exp_pc  = VECS[v][29:0];
      if (jump) tag = "R6";
      else if (branch && zero) tag = "R4";
      else tag = "R3";
      @(posedge clk);
      #1;
      check($sformatf("%s vector %0d pc", tag, v), 32'(pc), 32'(exp_pc));
      check($sformatf("R2 vector %0d fetch_addr", v), fetch_addr, {exp_pc, 2'b00});
      @(negedge clk);
    end

    // reset beats a jump (R1)
    rst = 1'b1; jump = 1'b1; jtarget = 26'h5;
    @(posedge clk); #1;
    check("R1 reset over jump", 32'(pc), 32'h0);
    @(negedge clk);
    rst = 1'b0; jump = 1'b0; branch = 1'b0; zero = 1'b0;
    @(posedge clk); #1;
    check("R3 step after reset", 32'(pc), 32'h1);
    check("R9 instr at 1", instr, word_at(1));

    // rewrite the word being fetched, counter held by jump to itself (R9)
    @(negedge clk);
    jump = 1'b1; jtarget = 26'h1;
    load_en = 1'b1; load_addr = 6'd1; load_data = 32'hDEAD_BEEF;
    #1;
    check("R9 no write before edge", instr, word_at(1));
    @(posedge clk); #1;
    check("R6 held pc", 32'(pc), 32'h1);
    check("R9 write visible", instr, 32'hDEAD_BEEF);
    @(negedge clk);
    load_en = 1'b0; jump = 1'b0;

    finish_run();
  end

endmodule